// File: doc/BRIEF.md
# Sleep and Idle Power-Mode Controller

This block decides which clock domains of a small processor subsystem are running. The core sends it a single-cycle request that names one of two low-power modes. In Idle the CPU clock stops and the peripheral clock keeps running. In Sleep the CPU clock, the peripheral clock and the system clock source all stop. The block drives clock-enable outputs for the CPU domain, the peripheral domain and the main oscillator. It also drives a clear strobe and a slow-clock enable for a watchdog, and an enable for the clock-fail monitor.

Three events end a low-power mode: an interrupt line that is both pending and individually enabled, a watchdog time-out, or reset. After Sleep the block waits for an oscillator-ready input before it restarts the CPU. A clock-source selection register loads the requested source only while the core is running. A wake-up therefore always resumes on the source that was active before the low-power mode. A two-bit status output reports the current mode. A sticky flag records whether the most recent wake-up came from the watchdog.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: Synchronous reset returns the block to run: status 2'b00, CPU, peripheral, oscillator, slow-clock and monitor enables all 1, watchdog clear 0, watchdog-wake flag 0, source register at its reset value. Reset wins over any wake event in the same cycle.
- R2: A request with `mode_req_sleep`=1, accepted in run, leads to one entry cycle. In that cycle the status is 2'b10, the CPU and peripheral enables are 0, the oscillator enable is 1, and `wdt_clr` equals `wdt_enabled`. The next cycle is the Sleep state, with `wdt_clr` back at 0.
- R3: In the Sleep state the CPU and peripheral enables are 0. `osc_en` is 0 when `src_onchip` is 1 and stays 1 when `src_onchip` is 0.
- R4: A request with `mode_req_sleep`=0, accepted in run, gives Idle on the next cycle: status 2'b01, CPU enable 0, peripheral, oscillator, slow-clock and monitor enables 1.
- R5: A wake event is a watchdog time-out or any bit set in both `irq_pend` and `irq_en`. A pending bit whose enable is 0 does not wake the block.
- R6: A wake event in Idle returns the block to run on the next cycle.
- R7: A wake event in Sleep leads to a wake state. This state keeps status 2'b10, keeps the CPU and peripheral enables at 0 and sets `osc_en` to 1. The block stays there until `osc_ready` is 1, and is in run on the cycle after that.
- R8: `lprc_en` equals `wdt_enabled` while the status is 2'b10, and is 1 otherwise.
- R9: `fscm_en` is 0 whenever the status is 2'b10, and 1 otherwise.
- R10: `src_sel` takes the value of `src_req` only at edges where the block is in run. In every other state it holds, so the source after wake-up is the one in use at entry.
- R11: A mode request that arrives while the block is not in run has no effect on the state.
- R12: On each wake from Idle or Sleep, `wake_by_wdt` is set to 1 if the watchdog time-out was present and to 0 otherwise. It holds its value until the next wake-up or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_req_valid | input | 1 | One-cycle low-power request strobe |
| mode_req_sleep | input | 1 | 1 selects Sleep, 0 selects Idle |
| irq_pend | input | N_IRQ | Pending interrupt lines |
| irq_en | input | N_IRQ | Per-line interrupt enables |
| wdt_timeout | input | 1 | Watchdog time-out event |
| wdt_enabled | input | 1 | Watchdog is enabled |
| osc_ready | input | 1 | Oscillator has restarted and is stable |
| src_onchip | input | 1 | Selected source is an on-chip oscillator |
| src_req | input | SRC_W | Requested clock source code |
| src_sel | output | SRC_W | Held clock source selection |
| cpu_clk_en | output | 1 | CPU domain clock enable |
| per_clk_en | output | 1 | Peripheral domain clock enable |
| osc_en | output | 1 | Main oscillator enable |
| wdt_clr | output | 1 | Watchdog clear strobe |
| lprc_en | output | 1 | Watchdog slow clock enable |
| fscm_en | output | 1 | Clock-fail monitor enable |
| mode_stat | output | 2 | 00 run, 01 idle, 10 sleep |
| wake_by_wdt | output | 1 | Last wake-up came from the watchdog |

## Verification
The bench checks that a second request during Sleep or Idle is ignored. A design that accepted it would move from Idle into Sleep or run a second watchdog clear. It holds `osc_ready` low in the wake state, where a careless design would restart the CPU too early. It also checks that an interrupt pending on a disabled line causes no wake-up. It changes the requested source during Sleep and checks that the selection stays frozen, which a design that reloaded it outside run would not do. Finally it raises reset together with a wake event while the watchdog-wake flag is set, so a design that lets the wake logic win would leave the flag at 1.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [2:0] {
        ST_RUN     = 3'd0,
        ST_SLP_ENT = 3'd1,
        ST_SLEEP   = 3'd2,
        ST_IDLE    = 3'd3,
        ST_WAKE    = 3'd4
    } pm_state_e;

    typedef enum logic [1:0] {
        MD_RUN   = 2'b00,
        MD_IDLE  = 2'b01,
        MD_SLEEP = 2'b10
    } pm_mode_e;

    typedef struct packed {
        logic cpu;
        logic per;
        logic osc;
        logic wdt_clr;
        logic lprc;
        logic fscm;
    } pm_gate_t;

    localparam pm_gate_t GATE_RUN = '{cpu: 1'b1, per: 1'b1, osc: 1'b1,
                                      wdt_clr: 1'b0, lprc: 1'b1, fscm: 1'b1};

    function automatic logic is_sleep_family(pm_state_e s);
        return (s == ST_SLP_ENT) || (s == ST_SLEEP) || (s == ST_WAKE);
    endfunction

    function automatic pm_mode_e mode_of(pm_state_e s);
        if (is_sleep_family(s)) return MD_SLEEP;
        if (s == ST_IDLE)       return MD_IDLE;
        return MD_RUN;
    endfunction

endpackage

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect #(
    parameter int N_IRQ = 4
) (
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             wdt_timeout,
    output logic             wake_any,
    output logic             wake_wdt
);
    logic [N_IRQ-1:0] hit;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_line
        assign hit[i] = irq_pend[i] & irq_en[i];
    end

    assign wake_wdt = wdt_timeout;
    assign wake_any = (|hit) | wdt_timeout;
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
    import pwr_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req_valid,
    input  logic      req_sleep,
    input  logic      wake_any,
    input  logic      wake_wdt,
    input  logic      osc_ready,
    output pm_state_e state,
    output logic      wake_by_wdt
);
    pm_state_e nxt;
    logic      waking;

    assign waking = wake_any && ((state == ST_SLEEP) || (state == ST_IDLE));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:     if (req_valid) nxt = req_sleep ? ST_SLP_ENT : ST_IDLE;
            ST_SLP_ENT: nxt = ST_SLEEP;
            ST_SLEEP:   if (wake_any) nxt = ST_WAKE;
            ST_IDLE:    if (wake_any) nxt = ST_RUN;
            ST_WAKE:    if (osc_ready) nxt = ST_RUN;
            default:    nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_RUN;
            wake_by_wdt <= 1'b0;
        end else begin
            state <= nxt;
            if (waking) wake_by_wdt <= wake_wdt;
        end
    end
endmodule

// File: rtl/pwr_gate_decode.sv
module pwr_gate_decode
    import pwr_mode_pkg::*;
(
    input  pm_state_e state,
    input  logic      wdt_enabled,
    input  logic      src_onchip,
    output pm_gate_t  gate,
    output pm_mode_e  mode
);
    always_comb begin
        gate = GATE_RUN;
        if (is_sleep_family(state)) begin
            gate.cpu  = 1'b0;
            gate.per  = 1'b0;
            gate.fscm = 1'b0;
            gate.lprc = wdt_enabled;
        end
        unique case (state)
            ST_SLP_ENT: gate.wdt_clr = wdt_enabled;
            ST_SLEEP:   gate.osc     = ~src_onchip;
            ST_IDLE:    gate.cpu     = 1'b0;
            default:    ;
        endcase
    end

    assign mode = mode_of(state);
endmodule

// File: rtl/pwr_src_hold.sv
module pwr_src_hold #(
    parameter int               SRC_W   = 3,
    parameter logic [SRC_W-1:0] RST_SRC = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [SRC_W-1:0] src_req,
    output logic [SRC_W-1:0] src_q
);
    always_ff @(posedge clk) begin
        if (rst)       src_q <= RST_SRC;
        else if (load) src_q <= src_req;
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int               N_IRQ   = 4,
    parameter int               SRC_W   = 3,
    parameter logic [SRC_W-1:0] RST_SRC = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_req_valid,
    input  logic             mode_req_sleep,
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             wdt_timeout,
    input  logic             wdt_enabled,
    input  logic             osc_ready,
    input  logic             src_onchip,
    input  logic [SRC_W-1:0] src_req,
    output logic [SRC_W-1:0] src_sel,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             osc_en,
    output logic             wdt_clr,
    output logic             lprc_en,
    output logic             fscm_en,
    output logic [1:0]       mode_stat,
    output logic             wake_by_wdt
);
    logic      wake_any, wake_wdt;
    pm_state_e state;
    pm_gate_t  gate;
    pm_mode_e  mode;

    pwr_wake_detect #(.N_IRQ(N_IRQ)) i_wake (
        .irq_pend(irq_pend), .irq_en(irq_en), .wdt_timeout(wdt_timeout),
        .wake_any(wake_any), .wake_wdt(wake_wdt)
    );

    pwr_mode_fsm i_fsm (
        .clk(clk), .rst(rst), .req_valid(mode_req_valid), .req_sleep(mode_req_sleep),
        .wake_any(wake_any), .wake_wdt(wake_wdt), .osc_ready(osc_ready),
        .state(state), .wake_by_wdt(wake_by_wdt)
    );

    pwr_gate_decode i_dec (
        .state(state), .wdt_enabled(wdt_enabled), .src_onchip(src_onchip),
        .gate(gate), .mode(mode)
    );

    pwr_src_hold #(.SRC_W(SRC_W), .RST_SRC(RST_SRC)) i_src (
        .clk(clk), .rst(rst), .load(state == ST_RUN),
        .src_req(src_req), .src_q(src_sel)
    );

    assign cpu_clk_en = gate.cpu;
    assign per_clk_en = gate.per;
    assign osc_en     = gate.osc;
    assign wdt_clr    = gate.wdt_clr;
    assign lprc_en    = gate.lprc;
    assign fscm_en    = gate.fscm;
    assign mode_stat  = mode;
endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk #(
    parameter int SRC_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             osc_ready,
    input logic             wdt_enabled,
    input logic [SRC_W-1:0] src_sel,
    input logic             cpu_clk_en,
    input logic             per_clk_en,
    input logic             osc_en,
    input logic             wdt_clr,
    input logic             lprc_en,
    input logic             fscm_en,
    input logic [1:0]       mode_stat,
    input logic             wake_by_wdt
);
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (mode_stat == 2'b00 && cpu_clk_en && per_clk_en && osc_en &&
                 lprc_en && fscm_en && !wdt_clr && !wake_by_wdt)); // R1

    AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wdt_clr |=> (mode_stat == 2'b10 && !wdt_clr)); // R2

    AST_SLEEP_GATED: assert property (@(posedge clk) disable iff (rst)
        (mode_stat == 2'b10) |-> (!cpu_clk_en && !per_clk_en)); // R3

    AST_IDLE_PER_ON: assert property (@(posedge clk) disable iff (rst)
        (mode_stat == 2'b01) |-> (per_clk_en && !cpu_clk_en && osc_en)); // R4

    AST_WAIT_OSC: assert property (@(posedge clk) disable iff (rst)
        (mode_stat == 2'b10 && !osc_ready) |=> !cpu_clk_en); // R7

    AST_LPRC_SLEEP: assert property (@(posedge clk) disable iff (rst)
        (mode_stat == 2'b10) |-> (lprc_en == wdt_enabled)); // R8

    AST_FSCM_OFF: assert property (@(posedge clk) disable iff (rst)
        (mode_stat == 2'b10) |-> !fscm_en); // R9

    AST_SRC_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (mode_stat != 2'b00) |=> $stable(src_sel)); // R10

    AST_NO_IDLE_TO_SLEEP: assert property (@(posedge clk) disable iff (rst)
        (mode_stat == 2'b01) |=> (mode_stat != 2'b10)); // R11

    AST_FLAG_HELD_RUN: assert property (@(posedge clk) disable iff (rst)
        (mode_stat == 2'b00) |=> $stable(wake_by_wdt)); // R12
endmodule

bind pwr_mode_ctrl pwr_mode_chk #(.SRC_W(SRC_W)) i_chk (
    .clk(clk), .rst(rst), .osc_ready(osc_ready), .wdt_enabled(wdt_enabled),
    .src_sel(src_sel), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .osc_en(osc_en), .wdt_clr(wdt_clr), .lprc_en(lprc_en), .fscm_en(fscm_en),
    .mode_stat(mode_stat), .wake_by_wdt(wake_by_wdt)
);

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
    localparam int N_IRQ = 4;
    localparam int SRC_W = 3;
    localparam int NROWS = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             mode_req_valid = 1'b0, mode_req_sleep = 1'b0;
    logic [N_IRQ-1:0] irq_pend = '0, irq_en = '0;
    logic             wdt_timeout = 1'b0, wdt_enabled = 1'b0;
    logic             osc_ready = 1'b0, src_onchip = 1'b0;
    logic [SRC_W-1:0] src_req = '0;
    logic [SRC_W-1:0] src_sel;
    logic             cpu_clk_en, per_clk_en, osc_en, wdt_clr, lprc_en, fscm_en;
    logic [1:0]       mode_stat;
    logic             wake_by_wdt;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    pwr_mode_ctrl #(.N_IRQ(N_IRQ), .SRC_W(SRC_W)) i_pwr_mode_ctrl (.*);

    // inputs {req_valid, req_sleep, irq, wdt_to, wdt_en, osc_rdy, onchip}
    // expected {mode[1:0], cpu, per, osc, clr, lprc, fscm}
    localparam logic [14:0] TBL [NROWS] = '{
        {7'b0000100, 8'b00111011},  // run
        {7'b1100100, 8'b10001110},  // sleep request -> entry
        {7'b0000101, 8'b10000010},  // sleep, on-chip source off
        {7'b1000101, 8'b10000010},  // request in sleep ignored
        {7'b0010101, 8'b10001010},  // irq -> wake
        {7'b0000100, 8'b10001010},  // osc not ready
        {7'b0000110, 8'b00111011},  // osc ready -> run
        {7'b1000100, 8'b01011011},  // idle
        {7'b1100100, 8'b01011011},  // sleep request in idle ignored
        {7'b0001100, 8'b00111011},  // watchdog -> run
        {7'b1100000, 8'b10001000},  // sleep entry, watchdog off
        {7'b0000000, 8'b10001000},  // sleep, external source stays on
        {7'b0001000, 8'b10001000},  // watchdog -> wake
        {7'b0000010, 8'b00111011},  // run
        {7'b1000000, 8'b01011011},  // idle
        {7'b0010000, 8'b00111011}   // irq -> run
    };

    function automatic string row_tag(int r);
        case (r)
            0:  return "R1";
            1:  return "R2 R8 R9";
            2:  return "R3 R9";
            3:  return "R11";
            4:  return "R5 R7";
            5:  return "R7";
            6:  return "R7";
            7:  return "R4";
            8:  return "R11";
            9:  return "R6";
            10: return "R8";
            11: return "R3";
            12: return "R5";
            13: return "R7";
            14: return "R4";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [6:0] v);
        @(negedge clk);
        mode_req_valid = v[6];
        mode_req_sleep = v[5];
        irq_pend       = v[4] ? 4'b0100 : 4'b0000;
        irq_en         = v[4] ? 4'b0110 : 4'b0000;
        wdt_timeout    = v[3];
        wdt_enabled    = v[2];
        osc_ready      = v[1];
        src_onchip     = v[0];
        @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] outs();
        return {mode_stat, cpu_clk_en, per_clk_en, osc_en, wdt_clr, lprc_en, fscm_en};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(outs(), 8'b00111011, "R1 reset enables");
        check(wake_by_wdt, 0, "R1 reset flag");
        check(src_sel, 0, "R1 reset source");
        @(negedge clk);
        rst = 1'b0;

        for (int r = 0; r < NROWS; r++) begin
            apply(TBL[r][14:8]);
            check(outs(), TBL[r][7:0], row_tag(r));
        end
        check(wake_by_wdt, 0, "R12 flag after irq wake");

        // R5: pending on a disabled line does not wake Idle
        apply(7'b1000000);
        @(negedge clk);
        mode_req_valid = 0; irq_pend = 4'b0001; irq_en = 4'b1110;
        @(posedge clk); #1;
        check(mode_stat, 2'b01, "R5 disabled irq no wake");
        apply(7'b0001000);
        check(mode_stat, 2'b00, "R6 wdt wake from idle");
        check(wake_by_wdt, 1, "R12 flag set by wdt");
        apply(7'b0000000);
        check(wake_by_wdt, 1, "R12 flag held");

        // R10: source frozen across sleep
        @(negedge clk); src_req = 3'd2;
        @(posedge clk); #1;
        check(src_sel, 3'd2, "R10 source load in run");
        apply(7'b1100100);
        @(negedge clk); mode_req_valid = 0; mode_req_sleep = 0; src_req = 3'd3;
        @(posedge clk); #1;
        apply(7'b0000100);
        check(mode_stat, 2'b10, "R3 still asleep");
        check(src_sel, 3'd2, "R10 source held in sleep");

        // R1: reset beats simultaneous wake
        @(negedge clk);
        rst = 1'b1; wdt_timeout = 1; irq_pend = 4'b1111; irq_en = 4'b1111;
        @(posedge clk); #1;
        check(outs(), 8'b00111011, "R1 reset over wake");
        check(wake_by_wdt, 0, "R1 reset clears flag");
        check(src_sel, 0, "R1 reset source over hold");
        @(negedge clk);
        rst = 1'b0; wdt_timeout = 0; irq_pend = '0; irq_en = '0;
        @(posedge clk); #1;
        check(src_sel, 3'd3, "R10 source reloads in run");

        finish_run();
    end
endmodule